// File: doc/BRIEF.md
# I2C Slave Write Receiver with Clock Stretching

This block is the receiving half of an I2C slave. It follows the bus lines with a system clock that runs much faster than SCL, and picks out START, repeated START and STOP. It compares the first byte after each START with a 7-bit address supplied on an input port. On a match it acknowledges the address, then shifts in and acknowledges each data byte a master writes. A completed byte moves into a one-byte holding register, where the host side collects it with a single-cycle read strobe.

When the host is slow, a second byte can finish shifting while the first is still waiting in the holding register. SCL is then held low after the last data bit of that second byte, before its acknowledge. The stretch lasts until the host reads. The read moves the waiting byte across and releases the clock, and the master then sees the acknowledge.

Both bus outputs are open-drain enables: a 1 pulls the line low and a 0 releases it.

Top module: `i2c_slave_rx`

## Requirements
- R1: A START clears `xfer_done`. A STOP sets `xfer_done` if an access was active, and clears `acc_active`.
- R2: An address byte whose upper seven bits equal `own_addr` is acknowledged: SDA is pulled low during the ninth SCL clock. The match sets `acc_active`, and `dir_read` takes the eighth bit (1 = master reads, 0 = master writes).
- R3: An address byte that does not match gets no acknowledge (SDA stays released in the ninth clock), and `acc_active` stays 0.
- R4: In a write access, a data byte completed while the holding register is empty is acknowledged and appears on `rd_data` with `rx_ready` set to 1.
- R5: A `rd_strobe` pulse while `rx_ready` is 1 clears `rx_ready`, unless a waiting byte moves in at the same time.
- R6: SCL is pulled low only when a new byte has completed and the holding register is still full. The stretch starts after the eighth bit of that byte, before its acknowledge.
- R7: A stretch lasts until the host reads. The read moves the waiting byte into the holding register, sets `rx_ready`, releases SCL, and the byte is then acknowledged.
- R8: `clk_wait` is 1 exactly while the block holds SCL low.
- R9: A repeated START followed by a non-matching address during an active access sets `xfer_done` and clears `acc_active`.
- R10: A `rd_strobe` pulse while `rx_ready` is 0 has no effect: `rx_ready` stays 0 and `rd_data` keeps its value.
- R11: After reset, every flag is 0 and both bus outputs are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 7 | Slave address to match |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| rd_strobe | input | 1 | One-cycle host read of the holding register |
| scl_drive_low | output | 1 | 1 pulls SCL low (stretch) |
| sda_drive_low | output | 1 | 1 pulls SDA low (acknowledge) |
| rd_data | output | 8 | Holding register |
| rx_ready | output | 1 | Holding register has an unread byte |
| acc_active | output | 1 | Address matched, access in progress |
| dir_read | output | 1 | R/W bit of the matched address |
| clk_wait | output | 1 | Clock stretch in progress |
| xfer_done | output | 1 | Access ended by STOP or by a foreign repeated-START address |

## Verification
Every bus edge passes through two synchronizer flops and one edge-detect flop, so a flag or bus output reacts three system clocks after the line changes. A host read acts one clock after the strobe. The bench's master holds each SCL phase for ten system clocks and samples at the end of a phase, well past that three-clock latency. Host-side results are sampled on falling clock edges, a few cycles after the read strobe. A monitor compares `clk_wait` with `scl_drive_low` and with the bench's own record of when a stretch is allowed, on every clock.

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-2:0] own_addr,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          rd_strobe,
  output logic          scl_drive_low,
  output logic          sda_drive_low,
  output logic [DW-1:0] rd_data,
  output logic          rx_ready,
  output logic          acc_active,
  output logic          dir_read,
  output logic          clk_wait,
  output logic          xfer_done
);
  localparam int CW = $clog2(DW + 1);

  typedef enum logic [2:0] {IDLE, ADDR, AACK, DATA, STALL, DACK, SKIP} st_t;
  st_t st;

  logic [SYNC_STAGES:0] scl_sh, sda_sh;
  logic [DW-1:0] shreg, hold;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-1:0], scl_in};
      sda_sh <= {sda_sh[SYNC_STAGES-1:0], sda_in};
    end

  wire scl_s = scl_sh[SYNC_STAGES-1];
  wire scl_p = scl_sh[SYNC_STAGES];
  wire sda_s = sda_sh[SYNC_STAGES-1];
  wire sda_p = sda_sh[SYNC_STAGES];
  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire start_c = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c = scl_s & scl_p & ~sda_p & sda_s;
  wire byte_in = scl_fall && (cnt == CW'(DW));
  wire take_bit = scl_rise && (cnt < CW'(DW));

  assign rd_data = hold;
  assign clk_wait = scl_drive_low;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE;
      cnt <= '0;
      shreg <= '0;
      hold <= '0;
      rx_ready <= 1'b0;
      acc_active <= 1'b0;
      dir_read <= 1'b0;
      xfer_done <= 1'b0;
      scl_drive_low <= 1'b0;
      sda_drive_low <= 1'b0;
    end else begin
      if (rd_strobe && rx_ready) rx_ready <= 1'b0;
      if (start_c) begin
        st <= ADDR;
        cnt <= '0;
        xfer_done <= 1'b0;
        scl_drive_low <= 1'b0;
        sda_drive_low <= 1'b0;
      end else if (stop_c) begin
        st <= IDLE;
        if (acc_active) xfer_done <= 1'b1;
        acc_active <= 1'b0;
        scl_drive_low <= 1'b0;
        sda_drive_low <= 1'b0;
      end else begin
        if ((st == ADDR || st == DATA) && take_bit) begin
          shreg <= {shreg[DW-2:0], sda_s};
          cnt <= cnt + 1'b1;
        end
        case (st)
          ADDR:
            if (byte_in) begin
              if (shreg[DW-1:1] == own_addr) begin
                acc_active <= 1'b1;
                dir_read <= shreg[0];
                sda_drive_low <= 1'b1;
                st <= AACK;
              end else begin
                if (acc_active) xfer_done <= 1'b1;
                acc_active <= 1'b0;
                st <= IDLE;
              end
            end
          AACK, DACK:
            if (scl_fall) begin
              sda_drive_low <= 1'b0;
              cnt <= '0;
              st <= (st == AACK && dir_read) ? SKIP : DATA;
            end
          DATA:
            if (byte_in) begin
              sda_drive_low <= 1'b1;
              if (!rx_ready || rd_strobe) begin
                hold <= shreg;
                rx_ready <= 1'b1;
                st <= DACK;
              end else begin
                scl_drive_low <= 1'b1;
                st <= STALL;
              end
            end
          STALL:
            if (rd_strobe) begin
              hold <= shreg;
              rx_ready <= 1'b1;
              scl_drive_low <= 1'b0;
              st <= DACK;
            end
          default: ;
        endcase
      end
    end
endmodule

// File: rtl/i2c_slave_rx_chk.sv
module i2c_slave_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_strobe,
  input logic rx_ready,
  input logic acc_active,
  input logic dir_read,
  input logic scl_drive_low,
  input logic sda_drive_low
);
  // R6
  stretch_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> rx_ready);

  // R7
  stretch_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_drive_low && !rd_strobe |=> scl_drive_low);

  // R5
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ready) |-> $past(rd_strobe));

  // R4
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> acc_active && !dir_read);

  // R2
  ack_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_drive_low |-> acc_active);
endmodule

bind i2c_slave_rx i2c_slave_rx_chk chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .rd_strobe(rd_strobe),
  .rx_ready(rx_ready),
  .acc_active(acc_active),
  .dir_read(dir_read),
  .scl_drive_low(scl_drive_low),
  .sda_drive_low(sda_drive_low)
);

// File: tb/i2c_slave_rx_test.sv
module i2c_slave_rx_test;
  localparam int H = 10;
  logic clk = 1'b0, rst_n = 1'b0, rd_strobe = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [6:0] own_addr = 7'h2A;
  logic scl_drive_low, sda_drive_low, rx_ready, acc_active, dir_read, clk_wait, xfer_done;
  logic [7:0] rd_data;
  wire scl_line = scl_m & ~scl_drive_low;
  wire sda_line = sda_m & ~sda_drive_low;

  int n_chk = 0, n_fail = 0, mon_err = 0;
  bit stretch_ok = 1'b0, done = 1'b0;
  logic [7:0] model_q[$];

  always #10 clk = ~clk;

  i2c_slave_rx uut (.clk(clk), .rst_n(rst_n), .own_addr(own_addr), .scl_in(scl_line),
    .sda_in(sda_line), .rd_strobe(rd_strobe), .scl_drive_low(scl_drive_low),
    .sda_drive_low(sda_drive_low), .rd_data(rd_data), .rx_ready(rx_ready),
    .acc_active(acc_active), .dir_read(dir_read), .clk_wait(clk_wait), .xfer_done(xfer_done));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; waitc(H);
    scl_m = 1'b1; wait_scl_high(); waitc(H);
    sda_m = 1'b0; waitc(H);
    scl_m = 1'b0; waitc(H);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; waitc(H);
    scl_m = 1'b1; wait_scl_high(); waitc(H);
    sda_m = 1'b1; waitc(H);
  endtask

  task automatic m_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; waitc(H);
      scl_m = 1'b1; wait_scl_high(); waitc(H);
      scl_m = 1'b0; waitc(H);
    end
    sda_m = 1'b1; waitc(H);
    scl_m = 1'b1; wait_scl_high(); waitc(H);
    ack = sda_line;
    scl_m = 1'b0; waitc(H);
  endtask

  task automatic host_read(input string req);
    logic [7:0] exp;
    exp = model_q.pop_front();
    check(req, rd_data, exp);
    rd_strobe = 1'b1; waitc(1);
    rd_strobe = 1'b0; waitc(2);
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    // R8
    if (clk_wait !== scl_drive_low) mon_err++;
    // R6
    if (clk_wait && !stretch_ok) mon_err++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic ack;
    waitc(5); rst_n = 1'b1; waitc(3);
    // R11
    check("R11 outputs", {scl_drive_low, sda_drive_low, rx_ready, acc_active, dir_read, clk_wait, xfer_done}, 0);

    m_start();
    m_byte({7'h2A, 1'b0}, ack);
    check("R2 addr ack", ack, 0);
    check("R2 active/dir", {acc_active, dir_read}, 2'b10);

    m_byte(8'hA5, ack); model_q.push_back(8'hA5);
    check("R4 data ack", ack, 0);
    check("R4 ready", rx_ready, 1);
    host_read("R4 data");
    check("R5 ready cleared", rx_ready, 0);

    rd_strobe = 1'b1; waitc(1); rd_strobe = 1'b0; waitc(2);
    check("R10 empty read ready", rx_ready, 0);
    check("R10 empty read data", rd_data, 8'hA5);

    m_byte(8'h5A, ack); model_q.push_back(8'h5A);
    check("R4 second ack", {ack, rx_ready}, 2'b01);

    stretch_ok = 1'b1;
    fork
      begin
        m_byte(8'hC3, ack); model_q.push_back(8'hC3);
      end
      begin
        int t = 0;
        while (!clk_wait && t < 2000) begin waitc(1); t++; end
        waitc(30);
        check("R6 stretch active", scl_drive_low, 1);
        check("R8 wait flag", clk_wait, 1);
        check("R7 line held", scl_line, 0);
        host_read("R7 first byte during stretch");
        check("R8 wait cleared", clk_wait, 0);
        check("R7 ready after move", rx_ready, 1);
      end
    join
    stretch_ok = 1'b0;
    check("R7 ack after stretch", ack, 0);
    host_read("R7 waiting byte");

    m_stop();
    check("R1 stop flags", {xfer_done, acc_active}, 2'b10);

    m_start();
    check("R1 start clears done", xfer_done, 0);
    m_byte({7'h15, 1'b0}, ack);
    check("R3 nack", ack, 1);
    check("R3 inactive", acc_active, 0);
    m_stop();

    m_start();
    m_byte({7'h2A, 1'b1}, ack);
    check("R2 read dir ack", {ack, acc_active, dir_read}, 3'b011);
    m_stop();

    m_start();
    m_byte({7'h2A, 1'b0}, ack);
    m_byte(8'h11, ack); model_q.push_back(8'h11);
    host_read("R4 byte before restart");
    m_start();
    m_byte({7'h33, 1'b0}, ack);
    check("R9 nack", ack, 1);
    check("R9 flags", {xfer_done, acc_active}, 2'b10);
    m_stop();

    done = 1'b1;
    check("R8 R6 monitor errors", mon_err, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule